// File: doc/BRIEF.md
# Pipeline Exception Flush Controller

This block is the control side of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It shuts the pipeline down cleanly when a restartable exception is raised partway through an instruction. A data page fault is one example: it is only seen in the memory stage. Each stage reports three things to the block: whether it holds a live instruction, whether that instruction raises an exception, and the instruction's PC, cause code and branch flag.

When a request is accepted, the block acts on the next cycle:
- It strobes a trap injection into fetch.
- It zeroes the pipeline latches that now hold the faulting instruction and every younger one.
- It records the restart PC, the cause, and whether the restart instruction is a branch whose condition must be evaluated again.

Older instructions further down the pipeline keep their writes and retire. A pending state then covers the injected trap's trip to writeback, and further requests are ignored while it lasts.

The block assumes the pipeline advances one stage per cycle while a trap is pending. Stage indices are 0 = fetch, 1 = decode, 2 = execute, 3 = memory, 4 = writeback, and a higher index means an older instruction. Squash bit i clears the latch that holds the instruction now in stage i.

Top module: `pipe_flush_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every output is zero.
- R2: An exception request is accepted in a cycle where some stage has both valid and exception set and no trap is pending. inject_trap_o is then high for exactly the one cycle after that edge.
- R3: When a fault in stage f is accepted, squash_o has bits 1 through min(f+1,4) set in the next cycle. These are the latches that now hold the faulting instruction and all younger ones.
- R4: In that same cycle, squash bit 0 stays clear, since fetch receives the trap. Bits above f+1 also stay clear, so older instructions keep their writes. squash_o is zero in every other cycle.
- R5: epc_o takes the PC of the accepted faulting stage and holds it until the next accepted request.
- R6: When several stages raise valid exceptions in the same cycle, the highest stage index (the oldest instruction) wins. Its PC, cause and branch flag are the ones recorded.
- R7: restart_branch_o takes the branch flag of the accepted faulting stage and holds it.
- R8: cause_o takes the cause code of the accepted faulting stage and holds it.
- R9: trap_pending_o is high for exactly five cycles, starting in the cycle after acceptance. That covers the trap from fetch through writeback. A request in the cycle after it falls is accepted again.
- R10: Requests made while trap_pending_o is high are ignored. The cycle after such a request shows no inject strobe, a zero squash vector, and unchanged epc_o, cause_o and restart_branch_o.
- R11: An exception bit on a stage whose valid bit is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_valid_i | input | 5 | Per-stage live-instruction bit, index 0 = fetch |
| stage_exc_i | input | 5 | Per-stage exception request |
| stage_pc_i | input | 5*PC_W | Per-stage PC, stage i in bits [i*PC_W +: PC_W] |
| stage_cause_i | input | 5*CAUSE_W | Per-stage cause code, same packing |
| stage_branch_i | input | 5 | Per-stage flag: instruction is a branch |
| squash_o | output | 5 | Per-stage latch clear, one cycle after acceptance |
| inject_trap_o | output | 1 | One-cycle strobe forcing a trap into fetch |
| trap_pending_o | output | 1 | High while the injected trap travels to writeback |
| epc_o | output | PC_W | Saved restart PC |
| cause_o | output | CAUSE_W | Saved cause code |
| restart_branch_o | output | 1 | Saved restart instruction is a branch |

## Verification
The hardest case to reach is the edge of the pending window. This is a request in the last pending cycle, which must be dropped, followed by a request one cycle later, which must be taken. The stimulus counts cycles exactly from a memory-stage fault, places one request on the final pending cycle and another on the first free cycle, and checks the squash mask and restart state after each. A request in the middle of the window and a same-cycle execute-plus-memory collision, with distinct PCs and causes, cover the ignore and priority paths.

// File: rtl/pfc_pkg.sv
// Package: shared stage numbering for the flush controller.
// Assumes a fixed five-stage in-order pipeline; a higher index is older.
package pfc_pkg;
    localparam int NSTAGE = 5;
    localparam int IDX_W  = $clog2(NSTAGE);

    typedef logic [IDX_W-1:0] stg_idx_t;

    typedef enum logic [IDX_W-1:0] {
        STG_IF  = 3'd0,
        STG_ID  = 3'd1,
        STG_EX  = 3'd2,
        STG_MEM = 3'd3,
        STG_WB  = 3'd4
    } stage_e;
endpackage

// File: rtl/exc_prio_sel.sv
// Module: picks the oldest stage with a live exception request.
// Assumes a higher stage index holds an older instruction.
module exc_prio_sel
    import pfc_pkg::*;
#(
    parameter int NST = NSTAGE
) (
    input  logic [NST-1:0] valid_i,
    input  logic [NST-1:0] req_i,
    output logic           hit_o,
    output stg_idx_t       idx_o
);
    logic [NST-1:0] live;

    assign live  = valid_i & req_i;
    assign hit_o = |live;

    // Scan from young to old so the deepest live request is left standing.
    always_comb begin
        idx_o = stg_idx_t'(STG_IF);
        for (int i = 0; i < NST; i++) begin
            if (live[i]) idx_o = stg_idx_t'(i);
        end
    end
endmodule

// File: rtl/squash_mask_gen.sv
// Module: builds the per-latch clear mask for a fault in stage idx_i.
// Assumes the pipeline advances one stage before the mask is applied,
// so the faulting instruction then sits in stage idx_i+1.
module squash_mask_gen
    import pfc_pkg::*;
#(
    parameter int NST = NSTAGE
) (
    input  stg_idx_t       idx_i,
    output logic [NST-1:0] mask_o
);
    // Bit 0 never clears (fetch takes the trap); bits 1..idx+1 clear.
    for (genvar g = 0; g < NST; g++) begin : g_bit
        if (g == 0) begin : g_fetch
            assign mask_o[g] = 1'b0;
        end else begin : g_rest
            assign mask_o[g] = (g <= int'(idx_i) + 1);
        end
    end
endmodule

// File: rtl/trap_seq.sv
// Module: tracks the injected trap from fetch to writeback.
// Assumes no stalls while pending; a request is taken only when idle.
module trap_seq
    import pfc_pkg::*;
#(
    parameter int NST = NSTAGE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic take_o,
    output logic pending_o,
    output logic inject_o
);
    localparam int CNT_W = $clog2(NST);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NST - 1);

    logic [CNT_W-1:0] cnt;

    assign take_o = hit_i && !pending_o;

    // Pending window: set on acceptance, cleared after NST cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_o <= 1'b0;
            cnt       <= '0;
        end else if (take_o) begin
            pending_o <= 1'b1;
            cnt       <= '0;
        end else if (pending_o) begin
            if (cnt == LAST) pending_o <= 1'b0;
            else             cnt       <= cnt + 1'b1;
        end
    end

    // One-cycle trap injection strobe toward fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) inject_o <= 1'b0;
        else        inject_o <= take_o;
    end

    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> (cnt <= LAST));
    p_start_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> inject_o);
endmodule

// File: rtl/pipe_flush_ctrl.sv
// Module: top of the exception flush controller.
// Selects the oldest faulting stage, squashes it and younger work,
// records restart state and injects a trap. Assumes no stalls while a
// trap is pending and that stage PCs/causes are stable in their cycle.
module pipe_flush_ctrl
    import pfc_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSTAGE-1:0]       stage_valid_i,
    input  logic [NSTAGE-1:0]       stage_exc_i,
    input  logic [NSTAGE*PC_W-1:0]  stage_pc_i,
    input  logic [NSTAGE*CAUSE_W-1:0] stage_cause_i,
    input  logic [NSTAGE-1:0]       stage_branch_i,
    output logic [NSTAGE-1:0]       squash_o,
    output logic                    inject_trap_o,
    output logic                    trap_pending_o,
    output logic [PC_W-1:0]         epc_o,
    output logic [CAUSE_W-1:0]      cause_o,
    output logic                    restart_branch_o
);
    logic            hit;
    logic            take;
    stg_idx_t        sel_idx;
    logic [NSTAGE-1:0] mask;

    exc_prio_sel #(.NST(NSTAGE)) u_sel (
        .valid_i (stage_valid_i),
        .req_i   (stage_exc_i),
        .hit_o   (hit),
        .idx_o   (sel_idx)
    );

    squash_mask_gen #(.NST(NSTAGE)) u_mask (
        .idx_i  (sel_idx),
        .mask_o (mask)
    );

    trap_seq #(.NST(NSTAGE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .take_o    (take),
        .pending_o (trap_pending_o),
        .inject_o  (inject_trap_o)
    );

    // Squash mask is a one-cycle pulse after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) squash_o <= '0;
        else        squash_o <= take ? mask : '0;
    end

    // Restart state is captured on acceptance and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o            <= '0;
            cause_o          <= '0;
            restart_branch_o <= 1'b0;
        end else if (take) begin
            epc_o            <= stage_pc_i[int'(sel_idx)*PC_W +: PC_W];
            cause_o          <= stage_cause_i[int'(sel_idx)*CAUSE_W +: CAUSE_W];
            restart_branch_o <= stage_branch_i[sel_idx];
        end
    end

    p_inject_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inject_trap_o |=> !inject_trap_o);
    p_squash_with_inject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o != '0) |-> inject_trap_o);
    p_squash_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inject_trap_o |-> (!squash_o[0] && squash_o[1]));
    p_hold_when_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending_o |=> ($stable(epc_o) && $stable(cause_o) && !inject_trap_o));
endmodule

// File: tb/pipe_flush_ctrl_bench.sv
// Bench: scoreboard. The driver pushes the expected next-cycle outputs;
// the monitor pops and compares them 1 ns after each rising edge.
module pipe_flush_ctrl_bench;
    localparam int PC_W = 32;
    localparam int CW   = 4;
    localparam int NS   = 5;

    typedef struct {
        logic [NS-1:0]   sq;
        logic            inj;
        logic            pend;
        logic [PC_W-1:0] epc;
        logic [CW-1:0]   cause;
        logic            br;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]      valid = '0, exc = '0, brv = '0;
    logic [NS*PC_W-1:0] pcs = '0;
    logic [NS*CW-1:0]   causes = '0;
    logic [NS-1:0]      squash;
    logic               inject, pending, rbr;
    logic [PC_W-1:0]    epc;
    logic [CW-1:0]      cause;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0, cyc = 0;
    bit   done = 0;

    // Reference state derived from the requirements.
    bit              m_pend = 0;
    int              m_cnt = 0;
    logic [PC_W-1:0] m_epc = '0;
    logic [CW-1:0]   m_cause = '0;
    logic            m_br = 1'b0;

    always #2 clk = ~clk;

    pipe_flush_ctrl #(.PC_W(PC_W), .CAUSE_W(CW)) u_pipe_flush_ctrl (
        .clk(clk), .rst_n(rst_n),
        .stage_valid_i(valid), .stage_exc_i(exc),
        .stage_pc_i(pcs), .stage_cause_i(causes), .stage_branch_i(brv),
        .squash_o(squash), .inject_trap_o(inject), .trap_pending_o(pending),
        .epc_o(epc), .cause_o(cause), .restart_branch_o(rbr)
    );

    task automatic set_stage(input int s, input logic [PC_W-1:0] pc,
                             input logic [CW-1:0] c, input logic b);
        pcs[s*PC_W +: PC_W] = pc;
        causes[s*CW +: CW]  = c;
        brv[s]              = b;
    endtask

    // Drive one cycle at the falling edge and push its expected result.
    task automatic step(input logic rn, input logic [NS-1:0] v,
                        input logic [NS-1:0] e, input string tag);
        exp_t x;
        int   f;
        @(negedge clk);
        rst_n = rn; valid = v; exc = e;
        x.sq = '0; x.inj = 1'b0; x.tag = tag;
        f = -1;
        for (int i = 0; i < NS; i++) if (v[i] && e[i]) f = i;
        if (!rn) begin
            m_pend = 0; m_cnt = 0; m_epc = '0; m_cause = '0; m_br = 1'b0;
        end else if (!m_pend && f >= 0) begin
            x.inj = 1'b1;
            for (int i = 1; i < NS; i++) x.sq[i] = (i <= f + 1);
            m_epc = pcs[f*PC_W +: PC_W];
            m_cause = causes[f*CW +: CW];
            m_br = brv[f];
            m_pend = 1; m_cnt = 0;
        end else if (m_pend) begin
            if (m_cnt == NS - 1) m_pend = 0;
            else m_cnt++;
        end
        x.pend = m_pend; x.epc = m_epc; x.cause = m_cause; x.br = m_br;
        q.push_back(x);
    endtask

    // Monitor: compare one expected item per rising edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            n_cmp++;
            if (squash !== x.sq || inject !== x.inj || pending !== x.pend ||
                epc !== x.epc || cause !== x.cause || rbr !== x.br) begin
                n_bad++;
                $display("FAIL %s: got sq=%b inj=%b pend=%b epc=%h cause=%h br=%b exp sq=%b inj=%b pend=%b epc=%h cause=%h br=%b",
                         x.tag, squash, inject, pending, epc, cause, rbr,
                         x.sq, x.inj, x.pend, x.epc, x.cause, x.br);
            end
        end
    end

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, '0, '0, tag);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) set_stage(s, 32'h1000 + 32'(s*4), CW'(s + 1), 1'b0);
        step(1'b0, '0, '0, "R1 reset");
        step(1'b0, 5'b11111, 5'b01000, "R1 reset ignores request");
        idle(1, "R1 idle after reset");
        // R11: exception flag without valid
        step(1'b1, 5'b10111, 5'b01000, "R11 invalid stage ignored");
        idle(1, "R11 no pending");
        // R3/R5/R8: MEM fault with three younger instructions in flight
        set_stage(3, 32'hA000_0300, 4'hB, 1'b0);
        step(1'b1, 5'b01111, 5'b01000, "R3 MEM fault squash");
        // R10: mid-window request, R9 window length
        idle(1, "R9 pending");
        set_stage(2, 32'hDEAD_0200, 4'h7, 1'b1);
        step(1'b1, 5'b11111, 5'b00100, "R10 ignored while pending");
        idle(2, "R9 pending");
        // R9/R10: last pending cycle ignored, next free cycle accepted
        step(1'b1, 5'b11111, 5'b00100, "R10 last pending cycle ignored");
        // R4: EX fault leaves older bit 4 clear
        set_stage(2, 32'hB000_0200, 4'h5, 1'b0);
        step(1'b1, 5'b11111, 5'b00100, "R4 EX fault older kept");
        idle(5, "R9 window");
        // R6/R7: simultaneous EX and MEM faults, MEM wins with branch flag
        set_stage(2, 32'hC000_0200, 4'h2, 1'b0);
        set_stage(3, 32'hC000_0300, 4'hE, 1'b1);
        step(1'b1, 5'b11111, 5'b01100, "R6 MEM beats EX");
        idle(5, "R9 window");
        // R7: EX branch fault
        set_stage(2, 32'hE000_0200, 4'h9, 1'b1);
        step(1'b1, 5'b00111, 5'b00100, "R7 branch restart flag");
        idle(5, "R9 window");
        // R3: WB fault caps mask at the top stage; R2 strobe length
        set_stage(4, 32'hF000_0400, 4'h3, 1'b0);
        step(1'b1, 5'b11111, 5'b10001, "R3 WB fault cap");
        idle(6, "R2 strobe single");
        // R1: reset mid-operation
        step(1'b1, 5'b11111, 5'b00010, "R2 ID fault");
        step(1'b0, '0, '0, "R1 reset clears");
        idle(2, "R1 after reset");
        @(negedge clk); @(negedge clk);
        done = 1;
    end

    // Watchdog and final summary.
    initial begin
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got cycles=%0d expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule